// File: doc/BRIEF.md
# Cell Sender with Byte-Stream Handshake

This block is the sending end of a cell-oriented byte bus. A client hands it one fixed-size cell (53 bytes by default) in a single request, together with the whole cell as a wide argument. The block copies the cell into a local buffer and raises cell-available. It then streams the bytes to a receiver that paces the transfer with an active-low enable line. The first byte is marked with start-of-cell. The request is acknowledged by a one-cycle completion pulse that comes after cell-available has gone high.

A byte is consumed at a clock edge where cell-available is high and the receiver holds enable low. The next byte appears in the following cycle; otherwise the current byte stays on the bus. A pause input lets a test force cell-available low for exactly one beat in mid-cell, so the receiver's pause handling can be exercised. After the pause the stream resumes with the next byte. The block holds one cell at a time. A request that arrives while a cell is in flight is refused, and the busy output tells the client so.

Top module: `cell_tx_slave`

## Requirements
- R1: Out of reset, cell_avail, soc, busy and send_done are 0 and data_out is all zeros.
- R2: When send_req is high at a clock edge while busy is 0, the cell is accepted: in the next cycle cell_avail and busy are both 1. Byte i of send_cell occupies bits [i*BYTE_W +: BYTE_W].
- R3: An accepted request is answered by send_done high for exactly one cycle. That cycle is the second cycle after the accepting edge, one cycle after cell_avail rose.
- R4: After acceptance, the first edge with cell_avail high and rx_enb_n low makes the next cycle show soc = 1 with data_out = byte 0. soc stays 1 only while byte 0 is on the bus, once per cell.
- R5: Bytes are delivered in index order. data_out changes only in a cycle that follows a cycle with cell_avail high and rx_enb_n low; otherwise it holds its value.
- R6: A pause_req sampled high at an edge during streaming (other than the edge that consumes the last byte) drives cell_avail low for exactly one cycle. The next byte consumed after the pause is the one following the last byte consumed before it.
- R7: At the edge that consumes byte CELL_BYTES-1, cell_avail and busy both fall together, and they stay low until a new request is accepted.
- R8: A send_req while busy is 1 is refused. busy stays 1 and the cell being streamed is not altered.
- R9: rx_enb_n has no effect while the block is idle or while cell_avail is low: no byte is consumed and no soc appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| send_req | input | 1 | Begin of a send request |
| send_cell | input | CELL_BYTES*BYTE_W | Cell argument, byte 0 in the lowest bits |
| send_done | output | 1 | One-cycle end of an accepted request |
| busy | output | 1 | A cell is held or in flight; requests are refused |
| pause_req | input | 1 | Insert a one-beat pause in the stream |
| rx_enb_n | input | 1 | Receiver enable, active low |
| cell_avail | output | 1 | Cell available to the receiver |
| soc | output | 1 | Start-of-cell, marks byte 0 |
| data_out | output | BYTE_W | Byte currently on the bus |

## Verification
The interesting collision is a byte being consumed and a pause being requested at the same edge. The pause then starts right after an advance, and a faulty index update would skip or repeat a byte across the gap. The bench provokes this by keeping enable low while it pulses pause_req on a fixed cadence, and by mixing in a pseudo-random enable pattern. A scoreboard pops the expected bytes at every consuming cycle and judges the stream, so any skip or repeat shows up as a byte mismatch. A refused request is also placed in the middle of a transfer, and the same scoreboard confirms that the first cell is still delivered unchanged.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_WAIT = 2'd1,
      TX_XFER = 2'd2
   } tx_state_e;
endpackage

// File: rtl/cell_tx_buf.sv
module cell_tx_buf #(
   parameter int CELL_BYTES = 53,
   parameter int BYTE_W     = 8,
   localparam int IDX_W     = $clog2(CELL_BYTES),
   localparam int CELL_W    = CELL_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [CELL_W-1:0] cell_in,
   input  logic [IDX_W-1:0]  idx,
   input  logic              xfer,
   output logic [BYTE_W-1:0] data_out
);
   logic [BYTE_W-1:0] store [CELL_BYTES];

   for (genvar b = 0; b < CELL_BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)       store[b] <= '0;
         else if (load_en) store[b] <= cell_in[b*BYTE_W +: BYTE_W];
      end
   end

   always_comb begin
      data_out = '0;
      if (xfer) data_out = store[idx];
   end
endmodule

// File: rtl/cell_tx_seq.sv
module cell_tx_seq
   import cell_tx_pkg::*;
#(
   parameter int CELL_BYTES = 53,
   parameter bit PAUSE_EN   = 1'b1,
   localparam int IDX_W     = $clog2(CELL_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             send_req,
   input  logic             rx_enb_n,
   input  logic             pause_req,
   output logic             load_en,
   output logic [IDX_W-1:0] idx,
   output logic             xfer,
   output logic             cell_avail,
   output logic             busy,
   output logic             soc,
   output logic             send_done
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

   tx_state_e        state_q;
   logic [IDX_W-1:0] idx_q;
   logic             avail_q, ack_q, done_q;
   logic             pause_eff, accept, advance, finish, pause_hit;

   if (PAUSE_EN) begin : g_pause
      assign pause_eff = pause_req;
   end else begin : g_no_pause
      assign pause_eff = 1'b0;
   end

   assign accept    = send_req && (state_q == TX_IDLE);
   assign advance   = avail_q && !rx_enb_n && (state_q != TX_IDLE);
   assign finish    = advance && (state_q == TX_XFER) && (idx_q == LAST_IDX);
   assign pause_hit = pause_eff && (state_q == TX_XFER) && avail_q && !finish;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         idx_q   <= '0;
         avail_q <= 1'b0;
         ack_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         ack_q  <= accept;
         done_q <= ack_q;
         unique case (state_q)
            TX_IDLE: begin
               if (accept) begin
                  state_q <= TX_WAIT;
                  avail_q <= 1'b1;
                  idx_q   <= '0;
               end
            end
            TX_WAIT: begin
               if (advance) state_q <= TX_XFER;
            end
            TX_XFER: begin
               if (finish) begin
                  state_q <= TX_IDLE;
                  avail_q <= 1'b0;
                  idx_q   <= '0;
               end else begin
                  if (advance)      idx_q   <= idx_q + IDX_W'(1);
                  if (pause_hit)    avail_q <= 1'b0;
                  else if (!avail_q) avail_q <= 1'b1;
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign load_en    = accept;
   assign idx        = idx_q;
   assign xfer       = (state_q == TX_XFER);
   assign cell_avail = avail_q;
   assign busy       = (state_q != TX_IDLE);
   assign soc        = (state_q == TX_XFER) && (idx_q == '0);
   assign send_done  = done_q;

   a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
      send_req && !busy |=> cell_avail && busy);
   a_r3_done_after: assert property (@(posedge clk) disable iff (!rst_n)
      send_req && !busy |=> ##1 send_done);
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      send_done |=> !send_done);
   a_r4_soc_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soc) |-> $past(!rx_enb_n && cell_avail));
   a_r6_pause_one: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cell_avail) && busy |=> cell_avail);
   a_r7_end_together: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !cell_avail);
endmodule

// File: rtl/cell_tx_slave.sv
module cell_tx_slave #(
   parameter int CELL_BYTES = 53,
   parameter int BYTE_W     = 8,
   parameter bit PAUSE_EN   = 1'b1,
   localparam int IDX_W     = $clog2(CELL_BYTES),
   localparam int CELL_W    = CELL_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_req,
   input  logic [CELL_W-1:0] send_cell,
   output logic              send_done,
   output logic              busy,
   input  logic              pause_req,
   input  logic              rx_enb_n,
   output logic              cell_avail,
   output logic              soc,
   output logic [BYTE_W-1:0] data_out
);
   initial begin
      assert (CELL_BYTES >= 2) else $error("CELL_BYTES must be at least 2");
      assert (BYTE_W >= 1) else $error("BYTE_W must be at least 1");
   end

   logic             load_en, xfer;
   logic [IDX_W-1:0] idx;

   cell_tx_seq #(.CELL_BYTES(CELL_BYTES), .PAUSE_EN(PAUSE_EN)) seq_i (
      .clk(clk), .rst_n(rst_n), .send_req(send_req), .rx_enb_n(rx_enb_n),
      .pause_req(pause_req), .load_en(load_en), .idx(idx), .xfer(xfer),
      .cell_avail(cell_avail), .busy(busy), .soc(soc), .send_done(send_done)
   );

   cell_tx_buf #(.CELL_BYTES(CELL_BYTES), .BYTE_W(BYTE_W)) buf_i (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .cell_in(send_cell),
      .idx(idx), .xfer(xfer), .data_out(data_out)
   );

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$past(!rx_enb_n && cell_avail) |-> $stable(data_out));
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !send_req |=> !cell_avail && !soc);
endmodule

// File: tb/cell_tx_slave_tb_top.sv
module cell_tx_slave_tb_top;
   localparam int NB = 53;
   localparam int W  = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            send_req = 1'b0;
   logic [NB*W-1:0] send_cell = '0;
   logic            send_done, busy, cell_avail, soc;
   logic            pause_req = 1'b0;
   logic            rx_enb_n = 1'b1;
   logic [W-1:0]    data_out;

   int checks = 0;
   int errors = 0;
   int mode = 0;
   int pause_every = 0;
   logic [W-1:0] expq [$];

   always #10 clk = ~clk;

   cell_tx_slave #(.CELL_BYTES(NB), .BYTE_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_cell(send_cell),
      .send_done(send_done), .busy(busy), .pause_req(pause_req),
      .rx_enb_n(rx_enb_n), .cell_avail(cell_avail), .soc(soc),
      .data_out(data_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pat(input int kind, input int i);
      case (kind)
         0: pat = W'(i * 3 + 1);
         1: pat = W'(8'hA0 ^ i);
         default: pat = W'(255 - i * 5);
      endcase
   endfunction

   // receiver enable and pause driver
   initial begin
      logic [7:0] lfsr = 8'h5B;
      int cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         case (mode)
            0: rx_enb_n = 1'b1;
            1: rx_enb_n = 1'b0;
            2: rx_enb_n = cyc[0];
            default: rx_enb_n = lfsr[0];
         endcase
         pause_req = (pause_every != 0) && (cyc % pause_every == 0);
      end
   end

   // monitor / scoreboard
   initial begin
      logic in_cell = 1'b0;
      int cnt = 0;
      logic prev_take = 1'b0, prev_busy = 1'b0, prev_avail = 1'b0, prev_soc = 1'b0;
      logic pause_seen = 1'b0;
      logic [W-1:0] prev_data = '0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (pause_seen) begin
            chk("R6 cell_avail back after one pause beat", cell_avail, 1'b1);
            pause_seen = 1'b0;
         end
         if (prev_avail && !cell_avail && busy) pause_seen = 1'b1;
         if (busy && prev_busy && !prev_take && data_out !== prev_data)
            chk("R5 byte held without enable", data_out, prev_data);
         if (soc && !prev_soc) begin
            chk("R4 soc follows enable with cell_avail", prev_take, 1'b1);
            chk("R4 soc not inside a cell", in_cell, 1'b0);
            in_cell = 1'b1;
            cnt = 0;
         end
         if (in_cell && cell_avail && !rx_enb_n) begin
            if (expq.size() == 0) chk("R5 unexpected byte", 32'(data_out), 32'hFFFF);
            else chk("R5 byte order", 32'(data_out), 32'(expq.pop_front()));
            chk("R4 soc only on byte 0", soc, (cnt == 0));
            cnt++;
            if (cnt == NB) in_cell = 1'b0;
         end
         prev_take  = cell_avail && !rx_enb_n;
         prev_busy  = busy;
         prev_avail = cell_avail;
         prev_soc   = soc;
         prev_data  = data_out;
      end
   end

   task automatic send(input int kind, input logic refuse_test);
      @(negedge clk);
      for (int i = 0; i < NB; i++) begin
         send_cell[i*W +: W] = pat(kind, i);
         expq.push_back(pat(kind, i));
      end
      send_req = 1'b1;
      @(negedge clk);
      send_req = 1'b0;
      chk("R2 cell_avail after accept", cell_avail, 1'b1);
      chk("R2 busy after accept", busy, 1'b1);
      chk("R3 no send_done in first cycle", send_done, 1'b0);
      @(negedge clk);
      chk("R3 send_done in second cycle", send_done, 1'b1);
      @(negedge clk);
      chk("R3 send_done single cycle", send_done, 1'b0);
      if (refuse_test) begin
         repeat (3) @(negedge clk);
         for (int i = 0; i < NB; i++) send_cell[i*W +: W] = pat(2, i);
         send_req = 1'b1;
         @(negedge clk);
         send_req = 1'b0;
         chk("R8 busy stays while refused", busy, 1'b1);
         @(negedge clk);
         chk("R8 no new send_done on refusal", send_done, 1'b0);
      end
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      chk("R7 busy falls after last byte", busy, 1'b0);
      chk("R7 cell_avail low with busy", cell_avail, 1'b0);
      chk("R7 all bytes delivered", expq.size(), 0);
      repeat (3) @(negedge clk);
      chk("R7 cell_avail stays low", cell_avail, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 cell_avail", cell_avail, 1'b0);
      chk("R1 soc", soc, 1'b0);
      chk("R1 busy", busy, 1'b0);
      chk("R1 send_done", send_done, 1'b0);
      chk("R1 data_out", data_out, '0);
      rst_n = 1'b1;
      mode = 1;
      repeat (5) @(negedge clk);
      chk("R9 idle enable gives no cell_avail", cell_avail, 1'b0);
      chk("R9 idle enable gives no soc", soc, 1'b0);
      mode = 0;
      send(0, 1'b0);
      mode = 1;
      wait_idle();
      mode = 0;
      send(1, 1'b1);
      mode = 2;
      pause_every = 5;
      wait_idle();
      mode = 1;
      pause_every = 3;
      send(2, 1'b0);
      wait_idle();
      mode = 3;
      pause_every = 7;
      send(0, 1'b0);
      wait_idle();
      pause_every = 0;
      mode = 0;
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule